// File: doc/BRIEF.md
# Socket Status Change Interrupt Unit

This block is the host-facing register bank for a small group of removable-card sockets. The host reaches it through two ports. A write to the index port selects a socket and a register. Later data-port accesses read or write that register. Each socket has a live status view of its pins: both card-detect contacts, a two-bit battery code, write protect, ready and power-good. Each pin is resynchronised to the host clock. Every transition of card presence or of either battery bit is latched into a sticky change register.

A per-socket configuration register enables individual change sources and chooses one of sixteen interrupt lines. The unit raises that line while an enabled change is pending. Reading the change register acknowledges it. Two further registers per socket hold power and general control. They drive the card's output enable, card enable, automatic power switching, the two programming-voltage codes, the I/O-card flag and card reset.

Top module: `spc_top`

## Requirements
- R1: The index byte selects the socket with bits 7:6 and the register with bits 5:0. Sockets numbered NUM_SOCK or higher read 0x00 and ignore data writes.
- R2: Register 0x00 reads 0x82 (upper nibble 0x8) and ignores writes.
- R3: Register 0x01 reads {0, power-good, ready, write-protect, detect B, detect A, battery[1:0]}, sampled two clocks after the pins. Card present means both detect bits set. The register ignores writes.
- R4: Register 0x02 is read/write. Bit 7 drives out_en, bit 5 drives auto_pwr, bit 4 drives card_en, bits 1:0 drive vpp1 and bits 3:2 drive vpp2 (code 1 = 5 V, 2 = 12 V).
- R5: Register 0x03 is read/write. Bit 5 drives io_card. card_reset is high while bit 6 is clear. Bits 3:0 hold the card IRQ number.
- R6: Register 0x04 bit 3 is set by any transition of card present. Bit 1 is set by any transition of battery bit 1. Bit 0 is set by any transition of battery bit 0. A detect pin that changes while the other is low sets nothing. Other bits read 0 and host writes are ignored.
- R7: A data-port read of register 0x04 clears it. A transition that arrives in the same cycle as the read keeps its bit set.
- R8: Register 0x05 is read/write. Bits 7:4 give the change IRQ number. Bits 3, 1 and 0 enable change bits 3, 1 and 0.
- R9: chg_irq bit N, where N is the configured number, is high while any change bit is set with its enable. All other bits are low. Sockets are ORed together.
- R10: After reset all registers are zero. card_reset is high, out_en and card_en are low and chg_irq is zero.
- R11: Register indices other than 0x00 to 0x05 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_we | input | 1 | Load wdata into the index register |
| data_we | input | 1 | Write wdata to the selected register |
| data_re | input | 1 | Data-port read strobe (acknowledges the change register) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Selected register contents |
| det_a | input | NUM_SOCK | Card detect contact A per socket |
| det_b | input | NUM_SOCK | Card detect contact B per socket |
| batt | input | 2*NUM_SOCK | Battery code per socket (11 = good) |
| wr_prot | input | NUM_SOCK | Write protect per socket |
| ready | input | NUM_SOCK | Ready/busy per socket |
| pwr_ok | input | NUM_SOCK | Power active per socket |
| card_reset | output | NUM_SOCK | Card held in reset |
| out_en | output | NUM_SOCK | Card output enable |
| card_en | output | NUM_SOCK | Card enable |
| auto_pwr | output | NUM_SOCK | Automatic power switching |
| vpp1 | output | 2*NUM_SOCK | First programming-voltage code |
| vpp2 | output | 2*NUM_SOCK | Second programming-voltage code |
| io_card | output | NUM_SOCK | I/O card mode |
| chg_irq | output | 16 | One-hot change interrupt lines |

## Verification
The hardest case to reach is a change event that lands in the same clock edge as the acknowledging read of the change register. The bench first leaves a battery bit pending. It then toggles a detect pin on a falling edge and counts the two synchroniser stages. It raises the read strobe so that the read is sampled in the cycle where the detect event is live. The battery bit must be gone afterwards and the detect bit must still be set. The lone-detect-pin case and enabled versus disabled sources are also driven from the pins, and the interrupt vector is compared with the expected one-hot value.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int REG_W     = 6;
    localparam int IRQ_LINES = 16;

    localparam logic [REG_W-1:0] REG_ID   = 6'h00;
    localparam logic [REG_W-1:0] REG_STAT = 6'h01;
    localparam logic [REG_W-1:0] REG_PWR  = 6'h02;
    localparam logic [REG_W-1:0] REG_GCTL = 6'h03;
    localparam logic [REG_W-1:0] REG_CHG  = 6'h04;
    localparam logic [REG_W-1:0] REG_CCFG = 6'h05;

    localparam logic [7:0] ID_VALUE = 8'h82;

    // Field order equals the low seven bits of the status register
    typedef struct packed {
        logic       pwr_ok;
        logic       ready;
        logic       wr_prot;
        logic       det_b;
        logic       det_a;
        logic [1:0] batt;
    } pins_t;

    typedef struct packed {
        logic det;
        logic bat_warn;
        logic bat_dead;
    } evt_t;

    function automatic logic [IRQ_LINES-1:0] irq_line(input logic [3:0] n);
        irq_line = IRQ_LINES'(1) << n;
    endfunction

endpackage

// File: rtl/spc_sync.sv
module spc_sync
    import spc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins_in,
    output pins_t pins_sync,
    output evt_t  evt
);
    pins_t      s1_q, s2_q;
    logic       prev_pres_q;
    logic [1:0] prev_batt_q;
    logic       pres;

    assign pres = s2_q.det_a & s2_q.det_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q        <= '0;
            s2_q        <= '0;
            prev_pres_q <= 1'b0;
            prev_batt_q <= 2'b00;
        end else begin
            s1_q        <= pins_in;
            s2_q        <= s1_q;
            prev_pres_q <= pres;
            prev_batt_q <= s2_q.batt;
        end
    end

    assign pins_sync    = s2_q;
    assign evt.det      = pres ^ prev_pres_q;
    assign evt.bat_warn = s2_q.batt[1] ^ prev_batt_q[1];
    assign evt.bat_dead = s2_q.batt[0] ^ prev_batt_q[0];

endmodule

// File: rtl/spc_sock_regs.sv
module spc_sock_regs
    import spc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [REG_W-1:0]     reg_sel,
    input  logic [7:0]           wdata,
    input  pins_t                stat,
    input  evt_t                 evt,
    output logic [7:0]           rdata,
    output logic [7:0]           pc_q,
    output logic [7:0]           gctl_q,
    output logic [IRQ_LINES-1:0] irq_vec
);
    logic [7:0] ccfg_q, chg_q, set_bits, kept;
    logic       rd_chg, pending;

    assign set_bits = {4'b0000, evt.det, 1'b0, evt.bat_warn, evt.bat_dead};
    assign rd_chg   = rd_en && (reg_sel == REG_CHG);
    assign kept     = rd_chg ? 8'h00 : chg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            gctl_q <= '0;
            ccfg_q <= '0;
            chg_q  <= '0;
        end else begin
            if (wr_en) begin
                case (reg_sel)
                    REG_PWR:  pc_q   <= wdata;
                    REG_GCTL: gctl_q <= wdata;
                    REG_CCFG: ccfg_q <= wdata;
                    default:  ;
                endcase
            end
            chg_q <= kept | set_bits;
        end
    end

    always_comb begin
        case (reg_sel)
            REG_ID:   rdata = ID_VALUE;
            REG_STAT: rdata = {1'b0, stat};
            REG_PWR:  rdata = pc_q;
            REG_GCTL: rdata = gctl_q;
            REG_CHG:  rdata = chg_q;
            REG_CCFG: rdata = ccfg_q;
            default:  rdata = 8'h00;
        endcase
    end

    assign pending = |(chg_q[3:0] & {ccfg_q[3], 1'b0, ccfg_q[1:0]});
    assign irq_vec = pending ? irq_line(ccfg_q[7:4]) : '0;

    p_reset_clears_r10: assert property (@(posedge clk)
        rst |=> (pc_q == 8'h00 && gctl_q == 8'h00 && chg_q == 8'h00 && ccfg_q == 8'h00));

    p_chg_set_r6: assert property (@(posedge clk) disable iff (rst)
        evt.det |=> chg_q[3]);

    p_read_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_chg && !evt.det && !evt.bat_warn && !evt.bat_dead) |=> (chg_q == 8'h00));

    p_pc_write_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel == REG_PWR) |=> (pc_q == $past(wdata)));

    p_irq_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_vec));

endmodule

// File: rtl/spc_top.sv
module spc_top
    import spc_pkg::*;
#(
    parameter int NUM_SOCK = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  idx_we,
    input  logic                  data_we,
    input  logic                  data_re,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    input  logic [NUM_SOCK-1:0]   det_a,
    input  logic [NUM_SOCK-1:0]   det_b,
    input  logic [2*NUM_SOCK-1:0] batt,
    input  logic [NUM_SOCK-1:0]   wr_prot,
    input  logic [NUM_SOCK-1:0]   ready,
    input  logic [NUM_SOCK-1:0]   pwr_ok,
    output logic [NUM_SOCK-1:0]   card_reset,
    output logic [NUM_SOCK-1:0]   out_en,
    output logic [NUM_SOCK-1:0]   card_en,
    output logic [NUM_SOCK-1:0]   auto_pwr,
    output logic [2*NUM_SOCK-1:0] vpp1,
    output logic [2*NUM_SOCK-1:0] vpp2,
    output logic [NUM_SOCK-1:0]   io_card,
    output logic [IRQ_LINES-1:0]  chg_irq
);
    localparam int SOCK_W = 2;

    logic [7:0]        idx_q;
    logic [SOCK_W-1:0] sock_sel;
    logic [REG_W-1:0]  reg_sel;

    logic [7:0]           rd_arr  [NUM_SOCK];
    logic [IRQ_LINES-1:0] irq_arr [NUM_SOCK];

    always_ff @(posedge clk) begin
        if (rst)         idx_q <= '0;
        else if (idx_we) idx_q <= wdata;
    end

    assign sock_sel = idx_q[7:6];
    assign reg_sel  = idx_q[5:0];

    for (genvar g = 0; g < NUM_SOCK; g++) begin : g_sock
        pins_t      pins_raw, pins_s;
        evt_t       evt;
        logic       sel;
        logic [7:0] pc, gctl;

        assign sel      = (sock_sel == SOCK_W'(g));
        assign pins_raw = '{pwr_ok: pwr_ok[g], ready: ready[g], wr_prot: wr_prot[g],
                            det_b: det_b[g], det_a: det_a[g], batt: batt[2*g +: 2]};

        spc_sync u_sync (
            .clk       (clk),
            .rst       (rst),
            .pins_in   (pins_raw),
            .pins_sync (pins_s),
            .evt       (evt)
        );

        spc_sock_regs u_regs (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (data_we && sel),
            .rd_en   (data_re && sel),
            .reg_sel (reg_sel),
            .wdata   (wdata),
            .stat    (pins_s),
            .evt     (evt),
            .rdata   (rd_arr[g]),
            .pc_q    (pc),
            .gctl_q  (gctl),
            .irq_vec (irq_arr[g])
        );

        assign out_en[g]       = pc[7];
        assign auto_pwr[g]     = pc[5];
        assign card_en[g]      = pc[4];
        assign vpp1[2*g +: 2]  = pc[1:0];
        assign vpp2[2*g +: 2]  = pc[3:2];
        assign io_card[g]      = gctl[5];
        assign card_reset[g]   = ~gctl[6];
    end

    always_comb begin
        rdata   = 8'h00;
        chg_irq = '0;
        for (int i = 0; i < NUM_SOCK; i++) begin
            if (sock_sel == SOCK_W'(i)) rdata = rd_arr[i];
            chg_irq = chg_irq | irq_arr[i];
        end
    end

endmodule

// File: tb/tb_spc_top.sv
module tb_spc_top;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst, idx_we, data_we, data_re;
    logic [7:0]   wdata, rdata;
    logic [N-1:0] det_a, det_b, wr_prot, ready, pwr_ok;
    logic [2*N-1:0] batt, vpp1, vpp2;
    logic [N-1:0] card_reset, out_en, card_en, auto_pwr, io_card;
    logic [15:0]  chg_irq;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spc_top #(.NUM_SOCK(N)) dut (
        .clk(clk), .rst(rst), .idx_we(idx_we), .data_we(data_we), .data_re(data_re),
        .wdata(wdata), .rdata(rdata), .det_a(det_a), .det_b(det_b), .batt(batt),
        .wr_prot(wr_prot), .ready(ready), .pwr_ok(pwr_ok), .card_reset(card_reset),
        .out_en(out_en), .card_en(card_en), .auto_pwr(auto_pwr), .vpp1(vpp1),
        .vpp2(vpp2), .io_card(io_card), .chg_irq(chg_irq)
    );

    // {index, write data, expected read-back}
    localparam logic [23:0] TBL [11] = '{
        {8'h02, 8'hB5, 8'hB5},   // R4 socket0 power control
        {8'h43, 8'h25, 8'h25},   // R5 socket1 general control
        {8'h05, 8'h58, 8'h58},   // R8 socket0 change config
        {8'h45, 8'h93, 8'h93},   // R8 socket1 change config
        {8'h03, 8'h6A, 8'h6A},   // R5 socket0 general control
        {8'h82, 8'hFF, 8'h00},   // R1 absent socket 2
        {8'hC5, 8'hFF, 8'h00},   // R1 absent socket 3
        {8'h07, 8'hAA, 8'h00},   // R11 unused index
        {8'h00, 8'h00, 8'h82},   // R2 id ignores write
        {8'h01, 8'hFF, 8'h00},   // R3 status ignores write
        {8'h04, 8'hFF, 8'h00}    // R6 change reg ignores write
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_idx(input logic [7:0] v);
        @(negedge clk); idx_we = 1'b1; wdata = v;
        @(negedge clk); idx_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); data_we = 1'b1; wdata = v;
        @(negedge clk); data_we = 1'b0;
    endtask

    // sample at the falling edge with the strobe raised; the acknowledge takes effect at the next rising edge
    task automatic rd(output logic [7:0] v);
        @(negedge clk); data_re = 1'b1; v = rdata;
        @(negedge clk); data_re = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic rd_at(input logic [7:0] idx, output logic [7:0] v);
        set_idx(idx);
        rd(v);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; idx_we = 0; data_we = 0; data_re = 0; wdata = 0;
        det_a = 0; det_b = 0; batt = 0; wr_prot = 0; ready = 0; pwr_ok = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        check("R10 card_reset", 16'(card_reset), 16'(2'b11));
        check("R10 out_en", 16'(out_en), 16'h0);
        check("R10 card_en", 16'(card_en), 16'h0);
        check("R10 chg_irq", chg_irq, 16'h0);
        rd_at(8'h02, v); check("R10 power reg", 16'(v), 16'h0);
        rd_at(8'h45, v); check("R10 config reg", 16'(v), 16'h0);

        // R1 R2 R4 R5 R8 R11 vector table
        for (int i = 0; i < 11; i++) begin
            set_idx(TBL[i][23:16]);
            wr(TBL[i][15:8]);
            rd(v);
            check("R1/R2/R4/R5/R8/R11 table", 16'(v), 16'(TBL[i][7:0]));
        end
        rd_at(8'h40, v); check("R2 id socket1", 16'(v), 16'h82);

        // R4 R5 outputs from socket0 0xB5 / 0x6A, socket1 0x25
        check("R4 out_en", 16'(out_en), 16'(2'b01));
        check("R4 auto_pwr", 16'(auto_pwr), 16'(2'b01));
        check("R4 card_en", 16'(card_en), 16'(2'b01));
        check("R4 vpp1", 16'(vpp1), 16'(4'b0001));
        check("R4 vpp2", 16'(vpp2), 16'(4'b0001));
        check("R5 card_reset", 16'(card_reset), 16'(2'b10));
        check("R5 io_card", 16'(io_card), 16'(2'b11));

        // R3 status layout
        det_a[0] = 1; settle();
        rd_at(8'h01, v); check("R3 lone detect A", 16'(v), 16'h04);
        rd_at(8'h04, v); check("R6 lone detect no change", 16'(v), 16'h00);
        det_b[0] = 1; batt[1:0] = 2'b11; wr_prot[0] = 1; ready[0] = 1; pwr_ok[0] = 1; settle();
        rd_at(8'h01, v); check("R3 all pins", 16'(v), 16'h7F);
        check("R9 detect irq line 5", chg_irq, 16'h0020);
        rd_at(8'h04, v); check("R6 present+battery change", 16'(v), 16'h0B);
        rd(v); check("R7 cleared after read", 16'(v), 16'h00);
        check("R9 irq drops after ack", chg_irq, 16'h0);

        // R6 battery bit 0 only; disabled source raises no irq (R9)
        batt[0] = 0; settle();
        check("R9 disabled source no irq", chg_irq, 16'h0);
        rd(v); check("R6 battery dead bit", 16'(v), 16'h01);
        batt[1] = 0; settle();
        rd(v); check("R6 battery warn bit", 16'(v), 16'h02);

        // R7 event coincident with acknowledge
        batt[0] = 1; settle();            // leave bit0 pending
        @(negedge clk); det_b[0] = 0;     // present falls
        @(negedge clk);                   // first stage captured
        @(negedge clk); data_re = 1'b1;   // event live across next edge
        v = rdata;
        check("R7 pending before ack", 16'(v), 16'h01);
        @(negedge clk); data_re = 1'b0;
        rd(v); check("R7 coincident event kept", 16'(v), 16'h08);

        // R9 socket1 battery source on line 9, OR of sockets
        set_idx(8'h44);
        batt[2] = 1; settle();
        check("R9 socket1 line 9", chg_irq, 16'h0200);
        rd(v); check("R6 socket1 battery dead", 16'(v), 16'h01);
        check("R9 socket1 cleared", chg_irq, 16'h0);

        // R1 data read of absent socket does not touch real socket change bits
        det_b[1] = 1; det_a[1] = 1; settle();
        set_idx(8'h84); rd(v); check("R1 absent socket read", 16'(v), 16'h00);
        rd_at(8'h44, v); check("R1 socket1 change intact", 16'(v), 16'h08);

        // R10 reset again
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        check("R10 reset restores card_reset", 16'(card_reset), 16'(2'b11));
        check("R10 reset out_en", 16'(out_en), 16'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule